// File: doc/BRIEF.md
# DMA Write Coherence Controller with Shadow Tags

This block sits in front of the on-chip second-level SRAM. It stops the first-level data cache from holding stale copies of lines that a DMA engine overwrites. The controller keeps its own copy of the data cache's tags and valid bits. The data cache tells it about every line it fills and every line it drops, and the controller updates its copy from those messages.

Every DMA write is held while the controller looks up its address in the copy. On a miss, the DMA word goes to SRAM straight away. On a hit, the data cache is told to drop the line. If the line holds modified data, the cache streams it back, and the controller writes it to SRAM before the DMA word. In both cases the instruction cache gets an invalidate for the same line. It needs no writeback, because instruction lines are never modified.

Only one DMA write is in flight at a time. A ready signal holds the DMA off until the current write is finished.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset, `dma_ready` is 1, and `snp_req`, `mem_we` and `ic_inv` are 0.
- R2: A DMA write whose line is absent from the shadow copy starts no snoop. This covers a line that was never filled and a line whose set holds other tags. The write is accepted at clock edge k. `mem_we`, carrying the DMA address and data, is high for one cycle after edge k+1.
- R3: A DMA write whose line is present in the shadow copy raises `snp_req` after edge k+1. `snp_line` and `snp_way` name the matching line and way, and `snp_req` stays high until `snp_ack`.
- R4: A dirty line is returned as `WORDS` beats on `wb_valid` before `snp_ack`. Beat i is written to SRAM at line base plus i. The DMA word is written after all the beats, so the DMA data is what remains at the DMA address.
- R5: A clean snoop is acknowledged with no beats. The DMA word is then the only SRAM write, and it is issued on the cycle after the acknowledge.
- R6: Each DMA write gives exactly one `ic_inv` pulse, with `ic_inv_line` equal to the written line. The pulse occurs in the same cycle as the DMA word's SRAM write.
- R7: When a snoop is acknowledged, that line is cleared from the shadow copy, so a second write to the same line does not snoop.
- R8: An evict message, given as set plus way, removes the line from the shadow copy. A later fill into the other way makes snoops report that way.
- R9: `dma_ready` is low from the cycle after an accepted write until that write has finished. It is also low for the whole time `snp_req` is high.
- R10: A write to any word offset within a cached line snoops the whole line. `snp_line` is the address bits above the `log2(WORDS)` offset bits.
- R11: A fill of the same line that arrives in the same cycle as the DMA write is seen by that write's lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_valid | input | 1 | DMA write request |
| dma_ready | output | 1 | Controller can accept a DMA write |
| dma_addr | input | ADDR_W | DMA word address |
| dma_data | input | DATA_W | DMA write data |
| alc_valid | input | 1 | Data cache filled a line |
| alc_line | input | ADDR_W-log2(WORDS) | Line address of the fill |
| alc_way | input | WAY_W | Way of the fill |
| ev_valid | input | 1 | Data cache dropped a line |
| ev_set | input | log2(SETS) | Set of the dropped line |
| ev_way | input | WAY_W | Way of the dropped line |
| snp_req | output | 1 | Snoop-invalidate request to the data cache |
| snp_line | output | ADDR_W-log2(WORDS) | Line to invalidate |
| snp_way | output | WAY_W | Way holding that line |
| snp_ack | input | 1 | Snoop finished (after any writeback beats) |
| wb_valid | input | 1 | Dirty writeback beat |
| wb_data | input | DATA_W | Writeback beat data |
| mem_we | output | 1 | SRAM write strobe |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_wdata | output | DATA_W | SRAM write data |
| ic_inv | output | 1 | Invalidate pulse to the instruction cache |
| ic_inv_line | output | ADDR_W-log2(WORDS) | Line the instruction cache should invalidate |

## Verification
The bench fills every set and way of a small configuration. It then makes three sweeps of DMA writes against that state:
- Writes with foreign tags must all miss, which separates the tag compare from the set index.
- Writes to each filled line, at varying word offsets and with alternating dirty and clean responses, show both the choice of way and the order of writeback against commit.
- Repeated writes to the same lines must then miss, which shows that acknowledges clear the copy.

Evict-then-refill into the other way, and a fill that coincides with a write, test the update paths separately from the lookup.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_SNOOP  = 2'd2,
    ST_DONE   = 2'd3
  } coh_state_e;
endpackage

// File: rtl/coh_tag_ram.sv
// Simple dual-port tag store: one write port, one registered read port.
module coh_tag_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 5,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/coh_shadow.sv
// Shadow copy of the data cache tags: one tag RAM per way, valid bits in flops.
module coh_shadow #(
  parameter int SET_W = 3,
  parameter int TAG_W = 5,
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  localparam int SETS = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alc_en,
  input  logic [SET_W-1:0] alc_set,
  input  logic [TAG_W-1:0] alc_tag,
  input  logic [WAY_W-1:0] alc_way,
  input  logic             ev_en,
  input  logic [SET_W-1:0] ev_set,
  input  logic [WAY_W-1:0] ev_way,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_set,
  input  logic [WAY_W-1:0] clr_way,
  input  logic             lk_en,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way
);
  logic [WAYS-1:0]  vld [SETS];
  logic [SET_W-1:0] lk_set_q;
  logic [TAG_W-1:0] lk_tag_q;
  logic             byp_q;
  logic [WAY_W-1:0] byp_way_q;
  logic [TAG_W-1:0] byp_tag_q;
  logic [WAYS-1:0]  hit_vec;

  // valid bits: acknowledge clear, then evict, then fill (latest wins)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      if (clr_en) vld[clr_set][clr_way] <= 1'b0;
      if (ev_en)  vld[ev_set][ev_way]   <= 1'b0;
      if (alc_en) vld[alc_set][alc_way] <= 1'b1;
    end
  end

  // lookup context plus bypass for a fill written in the read cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_set_q  <= '0;
      lk_tag_q  <= '0;
      byp_q     <= 1'b0;
      byp_way_q <= '0;
      byp_tag_q <= '0;
    end else begin
      if (lk_en) begin
        lk_set_q <= lk_set;
        lk_tag_q <= lk_tag;
      end
      byp_q     <= lk_en && alc_en && (alc_set == lk_set);
      byp_way_q <= alc_way;
      byp_tag_q <= alc_tag;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] rd_tag;
    logic [TAG_W-1:0] eff_tag;

    coh_tag_ram #(.DEPTH(SETS), .W(TAG_W)) u_tags (
      .clk   (clk),
      .we    (alc_en && (alc_way == WAY_W'(w))),
      .waddr (alc_set),
      .wdata (alc_tag),
      .raddr (lk_set),
      .rdata (rd_tag)
    );

    assign eff_tag    = (byp_q && byp_way_q == WAY_W'(w)) ? byp_tag_q : rd_tag;
    assign hit_vec[w] = vld[lk_set_q][w] && (eff_tag == lk_tag_q);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |hit_vec;

  // R3
  one_way_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/coh_fsm.sv
// Per-request sequencer: lookup, optional snoop with writeback, commit.
module coh_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 2,
  parameter int SET_W  = 3,
  parameter int WAY_W  = 1,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int WORDS  = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_data,
  output logic              lk_en,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hit_way,
  output logic              clr_en,
  output logic [SET_W-1:0]  clr_set,
  output logic [WAY_W-1:0]  clr_way,
  output logic              snp_req,
  output logic [LINE_W-1:0] snp_line,
  output logic [WAY_W-1:0]  snp_way,
  input  logic              snp_ack,
  input  logic              wb_valid,
  input  logic [DATA_W-1:0] wb_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ic_inv,
  output logic [LINE_W-1:0] ic_inv_line
);
  coh_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [WAY_W-1:0]  way_q;
  logic [OFF_W:0]    beat_q;
  logic              ack_now;

  assign dma_ready = (state == ST_IDLE);
  assign lk_en     = dma_valid && dma_ready;
  assign ack_now   = (state == ST_SNOOP) && snp_ack && !wb_valid;
  assign clr_en    = ack_now;
  assign clr_set   = addr_q[OFF_W +: SET_W];
  assign clr_way   = way_q;
  assign snp_line  = addr_q[ADDR_W-1:OFF_W];
  assign snp_way   = way_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      way_q       <= '0;
      beat_q      <= '0;
      snp_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      ic_inv      <= 1'b0;
      ic_inv_line <= '0;
    end else begin
      mem_we <= 1'b0;
      ic_inv <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (dma_valid) begin
            addr_q <= dma_addr;
            data_q <= dma_data;
            state  <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            snp_req <= 1'b1;
            way_q   <= hit_way;
            beat_q  <= '0;
            state   <= ST_SNOOP;
          end else begin
            mem_we      <= 1'b1;
            mem_addr    <= addr_q;
            mem_wdata   <= data_q;
            ic_inv      <= 1'b1;
            ic_inv_line <= addr_q[ADDR_W-1:OFF_W];
            state       <= ST_DONE;
          end
        end
        ST_SNOOP: begin
          if (wb_valid) begin
            mem_we    <= 1'b1;
            mem_addr  <= {addr_q[ADDR_W-1:OFF_W], beat_q[OFF_W-1:0]};
            mem_wdata <= wb_data;
            beat_q    <= beat_q + 1'b1;
          end else if (snp_ack) begin
            snp_req     <= 1'b0;
            mem_we      <= 1'b1;
            mem_addr    <= addr_q;
            mem_wdata   <= data_q;
            ic_inv      <= 1'b1;
            ic_inv_line <= addr_q[ADDR_W-1:OFF_W];
            state       <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    dma_valid && dma_ready |=> !dma_ready);

  // R9
  snoop_blocks_dma_chk: assert property (@(posedge clk) disable iff (rst)
    snp_req |-> !dma_ready);

  // R3
  snoop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    snp_req && !snp_ack |=> snp_req);

  // R4
  wb_beats_chk: assert property (@(posedge clk) disable iff (rst)
    ack_now |-> (beat_q == 0 || beat_q == (OFF_W+1)'(WORDS)));

  // R4
  wb_in_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> snp_req);
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int WORDS  = 4,
  parameter int SETS   = 8,
  parameter int WAYS   = 2,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_data,
  input  logic              alc_valid,
  input  logic [LINE_W-1:0] alc_line,
  input  logic [WAY_W-1:0]  alc_way,
  input  logic              ev_valid,
  input  logic [SET_W-1:0]  ev_set,
  input  logic [WAY_W-1:0]  ev_way,
  output logic              snp_req,
  output logic [LINE_W-1:0] snp_line,
  output logic [WAY_W-1:0]  snp_way,
  input  logic              snp_ack,
  input  logic              wb_valid,
  input  logic [DATA_W-1:0] wb_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ic_inv,
  output logic [LINE_W-1:0] ic_inv_line
);
  logic             lk_en;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             clr_en;
  logic [SET_W-1:0] clr_set;
  logic [WAY_W-1:0] clr_way;

  coh_shadow #(
    .SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .alc_en  (alc_valid),
    .alc_set (alc_line[SET_W-1:0]),
    .alc_tag (alc_line[LINE_W-1:SET_W]),
    .alc_way (alc_way),
    .ev_en   (ev_valid),
    .ev_set  (ev_set),
    .ev_way  (ev_way),
    .clr_en  (clr_en),
    .clr_set (clr_set),
    .clr_way (clr_way),
    .lk_en   (lk_en),
    .lk_set  (dma_addr[OFF_W +: SET_W]),
    .lk_tag  (dma_addr[ADDR_W-1:OFF_W+SET_W]),
    .hit     (hit),
    .hit_way (hit_way)
  );

  coh_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .dma_valid   (dma_valid),
    .dma_ready   (dma_ready),
    .dma_addr    (dma_addr),
    .dma_data    (dma_data),
    .lk_en       (lk_en),
    .hit         (hit),
    .hit_way     (hit_way),
    .clr_en      (clr_en),
    .clr_set     (clr_set),
    .clr_way     (clr_way),
    .snp_req     (snp_req),
    .snp_line    (snp_line),
    .snp_way     (snp_way),
    .snp_ack     (snp_ack),
    .wb_valid    (wb_valid),
    .wb_data     (wb_data),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .ic_inv      (ic_inv),
    .ic_inv_line (ic_inv_line)
  );
endmodule

// File: tb/snoop_coh_ctrl_tb.sv
module snoop_coh_ctrl_tb;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int WORDS  = 4;
  localparam int SETS   = 8;
  localparam int LINE_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              dma_valid = 1'b0;
  logic              dma_ready;
  logic [ADDR_W-1:0] dma_addr = '0;
  logic [DATA_W-1:0] dma_data = '0;
  logic              alc_valid = 1'b0;
  logic [LINE_W-1:0] alc_line = '0;
  logic [0:0]        alc_way = '0;
  logic              ev_valid = 1'b0;
  logic [2:0]        ev_set = '0;
  logic [0:0]        ev_way = '0;
  logic              snp_req;
  logic [LINE_W-1:0] snp_line;
  logic [0:0]        snp_way;
  logic              snp_ack = 1'b0;
  logic              wb_valid = 1'b0;
  logic [DATA_W-1:0] wb_data = '0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              ic_inv;
  logic [LINE_W-1:0] ic_inv_line;

  int total = 0;
  int bad   = 0;

  logic [DATA_W-1:0] sram [1 << ADDR_W];
  int                log_a [16];
  int                log_d [16];
  int                log_n = 0;
  int                inv_n = 0;
  int                inv_line = 0;
  bit                snp_seen = 1'b0;

  always #2 clk = ~clk;

  snoop_coh_ctrl u_dut (
    .clk(clk), .rst(rst),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr), .dma_data(dma_data),
    .alc_valid(alc_valid), .alc_line(alc_line), .alc_way(alc_way),
    .ev_valid(ev_valid), .ev_set(ev_set), .ev_way(ev_way),
    .snp_req(snp_req), .snp_line(snp_line), .snp_way(snp_way), .snp_ack(snp_ack),
    .wb_valid(wb_valid), .wb_data(wb_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ic_inv(ic_inv), .ic_inv_line(ic_inv_line)
  );

  // SRAM and event model
  always @(posedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        sram[mem_addr] = mem_wdata;
        if (log_n < 16) begin
          log_a[log_n] = int'(mem_addr);
          log_d[log_n] = int'(mem_wdata);
        end
        log_n++;
      end
      if (ic_inv) begin
        inv_n++;
        inv_line = int'(ic_inv_line);
      end
      if (snp_req) snp_seen = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tagof(input int s, input int w);
    return (s * 3 + w * 5 + 1) % 32;
  endfunction

  function automatic int wbpat(input int line, input int i);
    return 16'hC000 + line * 4 + i;
  endfunction

  task automatic fill(input int line, input int way);
    @(negedge clk);
    alc_valid = 1'b1; alc_line = LINE_W'(line); alc_way = 1'(way);
    @(negedge clk);
    alc_valid = 1'b0;
  endtask

  task automatic drop(input int set, input int way);
    @(negedge clk);
    ev_valid = 1'b1; ev_set = 3'(set); ev_way = 1'(way);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_write(input int a, input int d, input bit exp_hit, input int exp_way,
                          input bit dirty, input bit alloc_same, input int alc_w);
    int line = a / WORDS;
    int nexp;
    log_n = 0; inv_n = 0; snp_seen = 1'b0;
    @(negedge clk);
    dma_valid = 1'b1; dma_addr = ADDR_W'(a); dma_data = DATA_W'(d);
    if (alloc_same) begin
      alc_valid = 1'b1; alc_line = LINE_W'(line); alc_way = 1'(alc_w);
    end
    @(negedge clk);
    dma_valid = 1'b0; alc_valid = 1'b0;
    chk(dma_ready == 1'b0, "R9", "ready after accept", int'(dma_ready), 0);
    if (!exp_hit) begin
      @(negedge clk);
      chk(mem_we == 1'b1, "R2", "miss commit timing", int'(mem_we), 1);
      chk(int'(mem_addr) == a && int'(mem_wdata) == d, "R2", "miss commit addr",
          int'(mem_addr), a);
      chk(ic_inv == 1'b1, "R6", "ic_inv with commit", int'(ic_inv), 1);
    end else begin
      @(negedge clk);
      chk(snp_req == 1'b1, "R3", "snoop raised", int'(snp_req), 1);
      chk(int'(snp_line) == line, "R10", "snoop line", int'(snp_line), line);
      chk(int'(snp_way) == exp_way, "R3", "snoop way", int'(snp_way), exp_way);
      chk(dma_ready == 1'b0, "R9", "ready during snoop", int'(dma_ready), 0);
      @(negedge clk);
      chk(snp_req == 1'b1 && log_n == 0, "R3", "snoop held, no commit", log_n, 0);
      if (dirty) begin
        for (int i = 0; i < WORDS; i++) begin
          wb_valid = 1'b1; wb_data = DATA_W'(wbpat(line, i));
          @(negedge clk);
        end
        wb_valid = 1'b0;
      end
      snp_ack = 1'b1;
      @(negedge clk);
      snp_ack = 1'b0;
      chk(mem_we == 1'b1 && int'(mem_addr) == a, "R5", "commit after ack",
          int'(mem_addr), a);
    end
    for (int k = 0; k < 8; k++) begin
      if (dma_ready) break;
      @(negedge clk);
    end
    chk(dma_ready == 1'b1, "R9", "ready returns", int'(dma_ready), 1);
    chk(snp_seen == exp_hit, exp_hit ? "R3" : "R2", "snoop issued", int'(snp_seen),
        int'(exp_hit));
    nexp = (exp_hit && dirty) ? WORDS + 1 : 1;
    chk(log_n == nexp, exp_hit && dirty ? "R4" : "R5", "sram write count", log_n, nexp);
    if (exp_hit && dirty && log_n == nexp) begin
      for (int i = 0; i < WORDS; i++) begin
        chk(log_a[i] == line * WORDS + i && log_d[i] == wbpat(line, i), "R4",
            "writeback beat", log_a[i], line * WORDS + i);
      end
      chk(log_a[WORDS] == a, "R4", "dma word last", log_a[WORDS], a);
    end
    chk(int'(sram[a]) == d, "R4", "final sram word", int'(sram[a]), d);
    chk(inv_n == 1 && inv_line == line, "R6", "icache invalidate line", inv_line, line);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(dma_ready == 1'b1, "R1", "reset ready", int'(dma_ready), 1);
    chk(snp_req == 1'b0 && mem_we == 1'b0 && ic_inv == 1'b0, "R1", "reset idle outputs",
        int'(snp_req) + int'(mem_we) + int'(ic_inv), 0);

    // R2: empty shadow copy
    do_write(10'h015, 16'h1111, 0, 0, 0, 0, 0);

    // fill every set and way
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++) fill(tagof(s, w) * SETS + s, w);

    // R2: foreign tags miss in every set
    for (int s = 0; s < SETS; s++)
      do_write(((tagof(s, 0) ^ 16) * SETS + s) * WORDS + 1, 16'h2000 + s, 0, 0, 0, 0, 0);

    // R3/R4/R5/R10: hits at varying offsets, dirty and clean
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++)
        do_write((tagof(s, w) * SETS + s) * WORDS + (s + w) % WORDS,
                 16'h3000 + s * 2 + w, 1, w, 1'((s + w) % 2), 0, 0);

    // R7: acknowledged lines are gone from the copy
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++)
        do_write((tagof(s, w) * SETS + s) * WORDS, 16'h4000 + s * 2 + w, 0, 0, 0, 0, 0);

    // R8: evict then refill into the other way
    fill(20 * SETS + 2, 0);
    drop(2, 0);
    do_write((20 * SETS + 2) * WORDS + 3, 16'h5001, 0, 0, 0, 0, 0);
    fill(20 * SETS + 2, 1);
    do_write((20 * SETS + 2) * WORDS + 2, 16'h5002, 1, 1, 0, 0, 0);

    // R11: fill arriving with the write
    do_write((9 * SETS + 5) * WORDS + 1, 16'h6001, 1, 1, 1, 1, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule